// File: doc/BRIEF.md
# Auto-Baud Single-Wire Key Status Responder

This block answers key-status requests from a host on one shared, pulled-up serial line. The host sends a single fixed request character at any bit rate inside a configured window. The block times the request to find the bit period, checks that the character and its stop bit are correct, and then replies with two status bytes at the same rate. The reply carries the state of ten keys.

The block drives the shared line only while the reply is on the wire. At all other times it leaves the line to the host and the pull-up. A second, receive-only input accepts the same request for hosts that cannot release the shared line, and the reply still goes out on the shared line. An active-low change flag tells the host that the key vector differs from the last one reported.

All timing is counted in cycles of an oversampling system clock. `MIN_BIT` and `MAX_BIT` give the accepted bit-period window in clocks. With the defaults, an 8 MHz clock covers 38,400 down to about 6,150 bit/s.

Top module: `keystat_responder`

## Requirements
- R1: A request of 0x50 on `line_in` is accepted at any bit period from `MIN_BIT` to `MAX_BIT` clocks and answered. The framing is one low start bit, eight data bits LSB first, no parity and one high stop bit.
- R2: Every reply bit lasts the bit period measured from the request, to within one clock.
- R3: The reply start bit begins between one and three bit periods after the end of the request's stop bit.
- R4: The reply has two 8N1 frames, sent back to back, LSB first. Byte 0 is 0x40 plus keys[5:0] in bits 0 to 5. Byte 1 is 0x40 plus keys[9:6] in bits 0 to 3. In both bytes bit 6 is 1 and bit 7 is 0, and bits 4 and 5 of byte 1 are 0. Keys 0, 2 and 7 active give 0x45 then 0x42.
- R5: `line_oe` is high only from the first reply start bit until the second stop bit has been driven high for one full bit period. It is low in the cycle that follows.
- R6: `change_n` is low when the key vector differs from the last reported vector and no request is being served. It is high from the acceptance of a request until the reply ends, so it is high before the reply begins.
- R7: The key vector is captured when the reply start bit begins. Key changes during the reply do not alter it.
- R8: A request on `rx_in` gives the same reply on the shared line as a request on `line_in`.
- R9: A character other than 0x50, or one whose stop bit is low, gets no reply and leaves `line_oe` low.
- R10: A request whose measured period is below `MIN_BIT` or above `MAX_BIT` gets no reply.
- R11: After reset `line_oe` is low, `line_out` is high and `change_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level seen on the shared line |
| line_oe | output | 1 | Drive enable for the shared line |
| line_out | output | 1 | Level driven onto the shared line when enabled |
| rx_in | input | 1 | Receive-only request input, idle high |
| keys | input | 10 | Current key states, bit n = key n active |
| change_n | output | 1 | Low while unreported key changes exist |

## Verification
The assertions assume that the host releases the shared line as soon as its stop bit ends, so that every edge on the line during a reply comes from the block. They also assume that request edges are far enough apart for the measured period to stay inside the configured window. The bench drives the line through a pull-up model that yields to `line_oe`, and it always returns the host side to high after the stop bit. It varies the keys only between transactions, except in the one case that changes them on purpose in the middle of a reply. Rejected requests, including those at rates outside the window, are framed so that no later slice of the character can be measured as a valid request.

// File: rtl/ksr_pkg.sv
package ksr_pkg;

    localparam int KEY_N   = 10;
    localparam int FRAME_N = 20;

    // Expected request character
    localparam logic [7:0] REQ_CHAR = 8'h50;

    typedef enum logic [1:0] {
        RX_ARM,
        RX_IDLE,
        RX_LOW,
        RX_BITS
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_GAP,
        TX_SHIFT
    } tx_state_e;

    // Two 8N1 characters, LSB first, index 0 leaves the wire first
    function automatic logic [FRAME_N-1:0] reply_frame(input logic [KEY_N-1:0] k);
        logic [7:0] lo_byte;
        logic [7:0] hi_byte;
        lo_byte = {2'b01, k[5:0]};
        hi_byte = {2'b01, 2'b00, k[9:6]};
        return {1'b1, hi_byte, 1'b0, 1'b1, lo_byte, 1'b0};
    endfunction

endpackage

// File: rtl/ksr_sync.sv
module ksr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    // Idle level of both inputs is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ksr_rx_frame.sv
module ksr_rx_frame
    import ksr_pkg::*;
#(
    parameter int MIN_BIT = 160,
    parameter int MAX_BIT = 1300,
    parameter int PER_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic             accept,
    output logic [PER_W-1:0] period
);

    localparam logic [PER_W-1:0] ONE   = 1;
    localparam logic [PER_W-1:0] MIN_P = MIN_BIT[PER_W-1:0];
    localparam logic [PER_W-1:0] MAX_P = MAX_BIT[PER_W-1:0];
    // Bits 4..7 followed by the stop bit, first sample in bit 0
    localparam logic [4:0]       TAIL  = {1'b1, REQ_CHAR[7:4]};

    typedef struct packed {
        rx_state_e        st;
        logic [PER_W-1:0] grp;
        logic [2:0]       rem;
        logic [PER_W-1:0] cnt;
        logic [2:0]       idx;
        logic [4:0]       smp;
        logic             acc;
    } rx_t;

    rx_t              q, d;
    logic [PER_W-1:0] est;
    logic [4:0]       smp_next;

    always_comb begin
        d        = q;
        d.acc    = 1'b0;
        est      = q.grp + ((q.rem >= 3'd3) ? ONE : '0);
        smp_next = {din, q.smp[4:1]};
        case (q.st)
            RX_ARM: begin
                if (din) d.st = RX_IDLE;
            end
            RX_IDLE: begin
                if (!din) begin
                    d.st  = RX_LOW;
                    d.grp = '0;
                    d.rem = 3'd1;
                end
            end
            RX_LOW: begin
                // Low stretch covers start bit and data bits 0..3: five periods
                if (din) begin
                    if (est < MIN_P || est > MAX_P) begin
                        d.st = RX_ARM;
                    end else begin
                        d.st  = RX_BITS;
                        d.grp = est;
                        d.cnt = (est >> 1) - ONE;
                        d.idx = '0;
                    end
                end else if (q.rem == 3'd4) begin
                    d.rem = '0;
                    d.grp = q.grp + ONE;
                    if (q.grp >= MAX_P) d.st = RX_ARM;
                end else begin
                    d.rem = q.rem + 3'd1;
                end
            end
            RX_BITS: begin
                if (q.cnt == '0) begin
                    d.smp = smp_next;
                    d.cnt = q.grp - ONE;
                    d.idx = q.idx + 3'd1;
                    if (q.idx == 3'd4) begin
                        d.st  = RX_ARM;
                        d.acc = (smp_next == TAIL);
                    end
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            default: d.st = RX_ARM;
        endcase
        if (!en) begin
            d.st  = RX_ARM;
            d.acc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= RX_ARM;
            q.grp <= '0;
            q.rem <= '0;
            q.cnt <= '0;
            q.idx <= '0;
            q.smp <= '0;
            q.acc <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign accept = q.acc;
    assign period = q.grp;

endmodule

// File: rtl/ksr_tx_reply.sv
module ksr_tx_reply
    import ksr_pkg::*;
#(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] period,
    input  logic [KEY_N-1:0] keys,
    output logic             busy,
    output logic             line_oe,
    output logic             line_out,
    output logic [KEY_N-1:0] reported
);

    localparam logic [PER_W-1:0] ONE = 1;

    typedef struct packed {
        tx_state_e          st;
        logic [PER_W-1:0]   per;
        logic [PER_W-1:0]   cnt;
        logic [4:0]         idx;
        logic [FRAME_N-1:0] frame;
        logic               oe;
        logic [KEY_N-1:0]   rep;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            TX_IDLE: begin
                if (start) begin
                    d.st  = TX_GAP;
                    d.per = period;
                    d.cnt = (period << 1) - ONE;
                end
            end
            TX_GAP: begin
                if (q.cnt == '0) begin
                    d.st    = TX_SHIFT;
                    d.frame = reply_frame(keys);
                    d.rep   = keys;
                    d.oe    = 1'b1;
                    d.cnt   = q.per - ONE;
                    d.idx   = '0;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            TX_SHIFT: begin
                if (q.cnt == '0) begin
                    if (q.idx == 5'(FRAME_N - 1)) begin
                        d.st    = TX_IDLE;
                        d.oe    = 1'b0;
                        d.frame = '1;
                    end else begin
                        d.frame = {1'b1, q.frame[FRAME_N-1:1]};
                        d.idx   = q.idx + 5'd1;
                        d.cnt   = q.per - ONE;
                    end
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= TX_IDLE;
            q.per   <= '0;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.frame <= '1;
            q.oe    <= 1'b0;
            q.rep   <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != TX_IDLE);
    assign line_oe  = q.oe;
    assign line_out = q.frame[0];
    assign reported = q.rep;

endmodule

// File: rtl/keystat_responder.sv
module keystat_responder
    import ksr_pkg::*;
#(
    parameter int MIN_BIT = 208,
    parameter int MAX_BIT = 1300,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out,
    input  logic             rx_in,
    input  logic [KEY_N-1:0] keys,
    output logic             change_n
);

    localparam int PER_W = $clog2(2 * MAX_BIT + 2);
    localparam int SRC_N = 2;

    logic [SRC_N-1:0]            raw_in, sync_in, acc;
    logic [SRC_N-1:0][PER_W-1:0] per;
    logic                        acc_any;
    logic [PER_W-1:0]            acc_per;
    logic                        tx_busy;
    logic [KEY_N-1:0]            reported;
    logic                        chg_d, chg_q;

    assign raw_in = {rx_in, line_in};

    ksr_sync #(.W(SRC_N), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        ksr_rx_frame #(
            .MIN_BIT(MIN_BIT),
            .MAX_BIT(MAX_BIT),
            .PER_W  (PER_W)
        ) u_rx (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (!tx_busy),
            .din   (sync_in[g]),
            .accept(acc[g]),
            .period(per[g])
        );
    end

    // Shared line wins a same-cycle tie
    assign acc_any = |acc;
    assign acc_per = acc[0] ? per[0] : per[1];

    ksr_tx_reply #(.PER_W(PER_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (acc_any),
        .period  (acc_per),
        .keys    (keys),
        .busy    (tx_busy),
        .line_oe (line_oe),
        .line_out(line_out),
        .reported(reported)
    );

    always_comb begin
        chg_d = !(tx_busy || acc_any) && (keys != reported);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= 1'b0;
        else        chg_q <= chg_d;
    end

    assign change_n = !chg_q;

endmodule

// File: rtl/ksr_checker.sv
module ksr_checker #(
    parameter int MIN_BIT = 208,
    parameter int MAX_BIT = 1300,
    parameter int PER_W   = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_oe,
    input logic             line_out,
    input logic             change_n,
    input logic             acc_any,
    input logic [PER_W-1:0] acc_per,
    input logic [9:0]       reported
);

    localparam logic [PER_W-1:0] MIN_P = MIN_BIT[PER_W-1:0];
    localparam logic [PER_W-1:0] MAX_P = MAX_BIT[PER_W-1:0];

    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_out);

    p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> $past(line_out));

    p_flag_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> change_n);

    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && $past(line_oe)) |-> $stable(reported));

    p_rate_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any |-> (acc_per >= MIN_P && acc_per <= MAX_P));

endmodule

bind keystat_responder ksr_checker #(
    .MIN_BIT(MIN_BIT),
    .MAX_BIT(MAX_BIT),
    .PER_W  (PER_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_oe (line_oe),
    .line_out(line_out),
    .change_n(change_n),
    .acc_any (acc_any),
    .acc_per (acc_per),
    .reported(reported)
);

// File: tb/tb_keystat_responder.sv
module tb_keystat_responder;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_B      = 8;
    localparam int MAX_B      = 64;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_drv = 1'b1;
    logic       rx_drv = 1'b1;
    logic [9:0] keys = '0;
    logic       line_oe, line_out, change_n;
    logic       bus;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    assign bus = line_oe ? line_out : host_drv;

    keystat_responder #(.MIN_BIT(MIN_B), .MAX_BIT(MAX_B)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (bus),
        .line_oe (line_oe),
        .line_out(line_out),
        .rx_in   (rx_drv),
        .keys    (keys),
        .change_n(change_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit via_rx, input logic v);
        if (via_rx) rx_drv = v;
        else        host_drv = v;
    endtask

    task automatic send_req(input bit via_rx, input logic [7:0] ch,
                            input int per, input bit bad_stop);
        logic [9:0] fr;
        fr = {~bad_stop, ch, 1'b0};
        for (int b = 0; b < 10; b++) begin
            drive(via_rx, fr[b]);
            repeat (per) @(negedge clk);
        end
        drive(via_rx, 1'b1);
    endtask

    // Checks the reply that follows a request whose stop bit just ended
    task automatic expect_reply(input int per, input logic [9:0] k, input bit want,
                                input string tag, input bit swap, input logic [9:0] k2);
        int         n;
        bit         seen;
        logic [19:0] got;
        logic [19:0] exp;
        logic [7:0] b0, b1;
        n = 0;
        seen = 1'b0;
        while (n < 4 * per + 16 && !seen) begin
            @(negedge clk);
            n++;
            if (bus == 1'b0) seen = 1'b1;
        end
        if (!want) begin
            check(!seen && !line_oe, tag, "no drive after rejected request", int'(seen), 0);
            return;
        end
        check(seen, tag, "reply present", int'(seen), 1);
        if (!seen) return;
        check(n >= per && n <= 3 * per, "R3", "turnaround cycles", n, 2 * per);
        check(change_n == 1'b1, "R6", "flag released at reply start", int'(change_n), 1);
        b0  = 8'h40 + {2'b00, k[5:0]};
        b1  = 8'h40 + {4'b0000, k[9:6]};
        exp = {1'b1, b1, 1'b0, 1'b1, b0, 1'b0};
        repeat (per / 2) @(negedge clk);
        got[0] = bus;
        for (int b = 1; b < 20; b++) begin
            repeat (per) @(negedge clk);
            got[b] = bus;
            if (swap && b == 5) keys = k2;
        end
        check(got[8:1] == b0, "R4", "reply byte 0", int'(got[8:1]), int'(b0));
        check(got[18:11] == b1, "R4", "reply byte 1", int'(got[18:11]), int'(b1));
        check(got == exp, "R2", "bit-period framing", int'(got), int'(exp));
        repeat (per - per / 2 - 1) @(negedge clk);
        check(line_oe == 1'b1, "R5", "driven through last stop bit", int'(line_oe), 1);
        @(negedge clk);
        check(line_oe == 1'b0, "R5", "released after last stop bit", int'(line_oe), 0);
        repeat (3) @(negedge clk);
        if (swap)
            check(change_n == 1'b0, "R7", "flag after keys moved mid-reply", int'(change_n), 0);
        else
            check(change_n == 1'b1, "R6", "flag stays released", int'(change_n), 1);
    endtask

    task automatic run(input bit via_rx, input int per, input logic [9:0] k);
        keys = k;
        repeat (2 * per) @(negedge clk);
        send_req(via_rx, 8'h50, per, 1'b0);
        expect_reply(per, k, 1'b1, via_rx ? "R8" : "R1", 1'b0, k);
    endtask

    task automatic reject(input bit via_rx, input logic [7:0] ch, input int per,
                          input bit bad_stop, input string tag);
        repeat (2 * per) @(negedge clk);
        send_req(via_rx, ch, per, bad_stop);
        expect_reply(per, keys, 1'b0, tag, 1'b0, keys);
    endtask

    initial begin
        int pers[7] = '{8, 11, 16, 23, 32, 45, 64};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(line_oe == 1'b0, "R11", "line_oe after reset", int'(line_oe), 0);
        check(line_out == 1'b1, "R11", "line_out after reset", int'(line_out), 1);
        check(change_n == 1'b1, "R11", "change_n after reset", int'(change_n), 1);

        // R6 flag raised by an unreported change
        keys = 10'h085;
        repeat (4) @(negedge clk);
        check(change_n == 1'b0, "R6", "flag on key change", int'(change_n), 0);
        // Keys 0, 2, 7 give 0x45 / 0x42 (R4)
        run(1'b0, 16, 10'h085);

        // R4 walking key
        for (int i = 0; i < 10; i++) run(i[0], 16, 10'(1 << i));
        run(1'b0, 12, 10'h3FF);
        run(1'b1, 12, 10'h000);

        // R1 / R2 / R8 period sweep over both inputs
        for (int j = 0; j < 7; j++) begin
            for (int s = 0; s < 2; s++) begin
                run(s[0], pers[j], 10'((j * 311 + s * 97 + 5) % 1024));
            end
        end

        // R7 snapshot held while keys move mid-reply
        keys = 10'h2A5;
        repeat (40) @(negedge clk);
        send_req(1'b0, 8'h50, 20, 1'b0);
        expect_reply(20, 10'h2A5, 1'b1, "R7", 1'b1, 10'h15A);

        // R9 bad characters and bad stop bit
        reject(1'b0, 8'h51, 32, 1'b0, "R9");
        reject(1'b1, 8'h70, 16, 1'b0, "R9");
        reject(1'b0, 8'hD0, 20, 1'b0, "R9");
        reject(1'b0, 8'h50, 16, 1'b1, "R9");
        // R10 rates outside the window
        reject(1'b0, 8'h50, 5, 1'b0, "R10");
        reject(1'b1, 8'h50, 80, 1'b0, "R10");
        // Recovery after rejects
        run(1'b0, 24, 10'h3C3);

        finish_run();
    end

endmodule